// File: doc/BRIEF.md
# Serial-Clock Hold Synchronization Detector

This block sits on the converter side of a serial read port and watches for a synchronization request. The serial clock normally idles low. A host asks for synchronization by holding the clock high while the converter's ready periods go by. Each ready period is marked by a one-cycle tick from the conversion timer. Once the clock has stayed high across four such ticks, the block takes over the shared data/ready pin. It drives the pin low for a single master-clock cycle and then holds it high. At the same time it holds the modulator in reset.

The synchronization instant is the next falling edge of the serial clock. On that edge the block lets the modulator run again and emits a one-cycle release strobe. A fixed, parameterised number of master-clock cycles later, it emits a one-cycle marker: the ready pulse at that point is the first one that carries valid data. If the host keeps the clock high for twenty ready periods or more, the request counts as over-long. The block raises a status flag, and the release that follows produces neither a strobe nor a valid-data marker.

All inputs are already synchronous to the master clock. The modulator, the filter and the normal data shifting lie outside this block.

Top module: `sclk_hold_sync`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all outputs are low: mod_rst, pin_ovr_en, pin_ovr_val, rel_stb, first_valid and hold_err.
- R2: The hold count advances by one on every rdy_tick sampled while sclk_in is high, and any cycle with sclk_in low clears it to zero.
- R3: When idle, the fourth counted tick starts a request. In the next cycle pin_ovr_en is 1 and pin_ovr_val is 0 for exactly one cycle. After that, pin_ovr_val is 1 while pin_ovr_en stays 1 until release.
- R4: mod_rst is 1 from the first override cycle until release, and is 0 at all other times.
- R5: During a request, the first clock edge that samples sclk_in low after it was sampled high is the release. In the following cycle rel_stb is 1 for one cycle, and mod_rst and pin_ovr_en are both 0.
- R6: first_valid is 1 for exactly one cycle, DELAY master-clock cycles after rel_stb (DELAY=6 by default), and at no other time.
- R7: If the 20th counted tick arrives during a request, hold_err goes to 1 in the next cycle. The release of that request then drops mod_rst and the override without pulsing rel_stb or first_valid.
- R8: hold_err stays at 1 until the next request is detected. It returns to 0 in the cycle in which that request's low override pulse appears.
- R9: A falling edge of sclk_in before the fourth counted tick cancels the pending request. Later ticks start counting again from zero.
- R10: rdy_tick sampled with sclk_in low has no effect on any output. Edges of sclk_in that occur while the block is waiting for the valid-data marker produce no further rel_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock, already synchronized to clk |
| rdy_tick | input | 1 | One-cycle pulse at the start of each ready period |
| mod_rst | output | 1 | Holds the modulator in reset while high |
| pin_ovr_en | output | 1 | Data/ready pin is driven by pin_ovr_val while high |
| pin_ovr_val | output | 1 | Level forced onto the data/ready pin |
| rel_stb | output | 1 | One-cycle pulse marking the synchronization instant |
| first_valid | output | 1 | One-cycle pulse marking the first ready period with valid data |
| hold_err | output | 1 | Set when the clock was held high for too many ready periods |

## Verification
The checker enforces these rules on every clock:
- The low override pulse lasts a single cycle.
- The modulator reset always begins with that pulse.
- Every release strobe follows a sampled falling edge of the serial clock and coincides with the modulator reset dropping.
- The valid-data marker arrives exactly DELAY cycles after the strobe.
- An over-long hold never ends with a strobe.

Some behaviours only the bench scenarios can show, because they depend on how many ready periods the clock was held:
- The exact tick on which a request starts.
- That a short hold is cancelled.
- That ticks with the clock low do nothing.
- That the error flag persists until the next request and is cleared by it.

// File: rtl/sclk_hold_sync_pkg.sv
package sclk_hold_sync_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PULSE = 3'd1,
    ST_HOLD  = 3'd2,
    ST_OVER  = 3'd3,
    ST_WAIT  = 3'd4
  } sync_st_t;

  // Next value of the hold count: cleared by a low clock, advanced by a
  // tick while high, never beyond the saturation value.
  function automatic int unsigned hold_next(int unsigned cur, logic hi,
                                            logic tick, int unsigned sat);
    if (!hi)
      return 0;
    if (tick && (cur < sat))
      return cur + 1;
    return cur;
  endfunction

  // Pin is overridden in every state that holds the modulator.
  function automatic logic holds_mod(sync_st_t st);
    return (st == ST_PULSE) || (st == ST_HOLD) || (st == ST_OVER);
  endfunction

  // Forced pin level: low only during the single pulse state.
  function automatic logic pin_level(sync_st_t st);
    return holds_mod(st) && (st != ST_PULSE);
  endfunction

endpackage

// File: rtl/shd_edge.sv
module shd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic sclk_fall
);
  logic sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sclk_q <= 1'b0;
    else
      sclk_q <= sclk_in;
  end

  assign sclk_fall = sclk_q & ~sclk_in;
endmodule

// File: rtl/shd_hold_cnt.sv
module shd_hold_cnt #(
  parameter int unsigned HMAX = 20,
  localparam int unsigned CW  = $clog2(HMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic          rdy_tick,
  output logic [CW-1:0] hold_cnt
);
  import sclk_hold_sync_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else
      hold_cnt <= CW'(hold_next(int'(hold_cnt), sclk_in, rdy_tick, HMAX));
  end
endmodule

// File: rtl/shd_seq.sv
module shd_seq #(
  parameter int unsigned TRIG  = 4,
  parameter int unsigned HMAX  = 20,
  parameter int unsigned DELAY = 6,
  localparam int unsigned CW   = $clog2(HMAX + 1),
  localparam int unsigned DW   = $clog2(DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_in,
  input  logic          rdy_tick,
  input  logic          sclk_fall,
  input  logic [CW-1:0] hold_cnt,
  output logic          detect_hit,
  output logic          over_hit,
  output logic          mod_rst,
  output logic          pin_ovr_en,
  output logic          pin_ovr_val,
  output logic          rel_stb,
  output logic          first_valid,
  output logic          hold_err
);
  import sclk_hold_sync_pkg::*;

  sync_st_t      st;
  logic [DW-1:0] dcnt;
  logic          rel_hit;

  assign detect_hit = (st == ST_IDLE) && sclk_in && rdy_tick &&
                      (hold_cnt == CW'(TRIG - 1));
  assign over_hit   = (st == ST_HOLD) && sclk_in && rdy_tick &&
                      (hold_cnt == CW'(HMAX - 1));
  assign rel_hit    = ((st == ST_PULSE) || (st == ST_HOLD)) && sclk_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      dcnt        <= '0;
      rel_stb     <= 1'b0;
      first_valid <= 1'b0;
      hold_err    <= 1'b0;
    end else begin
      rel_stb     <= 1'b0;
      first_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (detect_hit) begin
            st       <= ST_PULSE;
            hold_err <= 1'b0;
          end
        end
        ST_PULSE, ST_HOLD: begin
          if (rel_hit) begin
            st      <= ST_WAIT;
            rel_stb <= 1'b1;
            dcnt    <= DW'(DELAY - 1);
          end else if (over_hit) begin
            st       <= ST_OVER;
            hold_err <= 1'b1;
          end else begin
            st <= ST_HOLD;
          end
        end
        ST_OVER: begin
          if (sclk_fall)
            st <= ST_IDLE;
        end
        ST_WAIT: begin
          if (dcnt == '0) begin
            first_valid <= 1'b1;
            st          <= ST_IDLE;
          end else begin
            dcnt <= dcnt - 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mod_rst     = holds_mod(st);
  assign pin_ovr_en  = holds_mod(st);
  assign pin_ovr_val = pin_level(st);
endmodule

// File: rtl/sclk_hold_sync.sv
module sclk_hold_sync #(
  parameter int unsigned TRIG  = 4,
  parameter int unsigned HMAX  = 20,
  parameter int unsigned DELAY = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic rdy_tick,
  output logic mod_rst,
  output logic pin_ovr_en,
  output logic pin_ovr_val,
  output logic rel_stb,
  output logic first_valid,
  output logic hold_err
);
  localparam int unsigned CW = $clog2(HMAX + 1);

  logic          sclk_fall;
  logic [CW-1:0] hold_cnt;
  logic          detect_hit;
  logic          over_hit;

  shd_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (sclk_in),
    .sclk_fall(sclk_fall)
  );

  shd_hold_cnt #(.HMAX(HMAX)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .rdy_tick(rdy_tick),
    .hold_cnt(hold_cnt)
  );

  shd_seq #(.TRIG(TRIG), .HMAX(HMAX), .DELAY(DELAY)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_in    (sclk_in),
    .rdy_tick   (rdy_tick),
    .sclk_fall  (sclk_fall),
    .hold_cnt   (hold_cnt),
    .detect_hit (detect_hit),
    .over_hit   (over_hit),
    .mod_rst    (mod_rst),
    .pin_ovr_en (pin_ovr_en),
    .pin_ovr_val(pin_ovr_val),
    .rel_stb    (rel_stb),
    .first_valid(first_valid),
    .hold_err   (hold_err)
  );
endmodule

// File: rtl/sclk_hold_sync_chk.sv
module sclk_hold_sync_chk #(
  parameter int unsigned DELAY = 6,
  localparam int unsigned SW   = $clog2(DELAY + 2)
) (
  input logic clk,
  input logic rst_n,
  input logic sclk_in,
  input logic mod_rst,
  input logic pin_ovr_en,
  input logic pin_ovr_val,
  input logic rel_stb,
  input logic first_valid,
  input logic hold_err,
  input logic detect_hit
);
  logic [SW-1:0] since_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_rel <= '0;
    else if (rel_stb)
      since_rel <= SW'(1);
    else if ((since_rel != '0) && (since_rel <= SW'(DELAY)))
      since_rel <= since_rel + 1'b1;
  end

  // R3: the low override lasts one cycle only
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_ovr_en && !pin_ovr_val) |=> !(pin_ovr_en && !pin_ovr_val));

  // R3: a detection is followed by the low override pulse
  a_r3_detect_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    detect_hit |=> (pin_ovr_en && !pin_ovr_val && mod_rst));

  // R4: modulator reset always begins with the low pulse
  a_r4_rst_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mod_rst) |-> (pin_ovr_en && !pin_ovr_val));

  // R5: strobe follows a sampled falling edge and ends the reset
  a_r5_rel_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rel_stb |-> (!$past(sclk_in) && $past(sclk_in, 2) &&
                 $past(mod_rst) && !mod_rst && !pin_ovr_en));

  // R6: valid marker exactly DELAY cycles after the strobe
  a_r6_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    first_valid |-> (since_rel == SW'(DELAY)));

  // R6: strobe and marker never coincide
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rel_stb, first_valid}));

  // R7: an over-long hold ends without a strobe
  a_r7_no_rel_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_rst) && hold_err) |-> !rel_stb);
endmodule

bind sclk_hold_sync sclk_hold_sync_chk #(.DELAY(DELAY)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk_in    (sclk_in),
  .mod_rst    (mod_rst),
  .pin_ovr_en (pin_ovr_en),
  .pin_ovr_val(pin_ovr_val),
  .rel_stb    (rel_stb),
  .first_valid(first_valid),
  .hold_err   (hold_err),
  .detect_hit (detect_hit)
);

// File: tb/sclk_hold_sync_bench.sv
`timescale 1ns/1ps
module sclk_hold_sync_bench;
  localparam int DELAY = 6;
  localparam int PER   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk_in = 1'b0;
  logic rdy_tick = 1'b0;
  logic mod_rst, pin_ovr_en, pin_ovr_val, rel_stb, first_valid, hold_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state
  int  m_phase = 0;   // 0 idle, 1 low pulse, 2 held, 3 over-long, 4 waiting
  int  m_hold = 0;
  int  m_left = 0;
  bit  m_prev = 0;
  bit  e_rel = 0, e_fv = 0, e_err = 0;

  int n_pulse = 0, n_rel = 0, n_fv = 0, n_rst = 0;

  always #5 clk = ~clk;

  sclk_hold_sync #(.DELAY(DELAY)) u_sclk_hold_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .rdy_tick(rdy_tick),
    .mod_rst(mod_rst), .pin_ovr_en(pin_ovr_en), .pin_ovr_val(pin_ovr_val),
    .rel_stb(rel_stb), .first_valid(first_valid), .hold_err(hold_err)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    rdy_tick = ((cyc % PER) == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_hold = 0; m_left = 0; m_prev = 0;
      e_rel = 0; e_fv = 0; e_err = 0;
    end else begin
      bit fall;
      fall = m_prev && !sclk_in;
      e_rel = 0;
      e_fv = 0;
      case (m_phase)
        0: if (sclk_in && rdy_tick && m_hold == 3) begin m_phase = 1; e_err = 0; end
        1, 2: begin
          if (fall) begin m_phase = 4; e_rel = 1; m_left = DELAY - 1; end
          else if (m_phase == 2 && sclk_in && rdy_tick && m_hold == 19) begin
            m_phase = 3; e_err = 1;
          end else m_phase = 2;
        end
        3: if (fall) m_phase = 0;
        default: begin
          if (m_left == 0) begin e_fv = 1; m_phase = 0; end
          else m_left = m_left - 1;
        end
      endcase
      if (!sclk_in) m_hold = 0;
      else if (rdy_tick && m_hold < 20) m_hold = m_hold + 1;
      m_prev = sclk_in;
    end
  end

  task automatic cmp(string tag, logic act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic cnt_chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit held;
      held = (m_phase >= 1 && m_phase <= 3);
      cmp("R4 mod_rst", mod_rst, held);
      cmp("R3 pin_ovr_en", pin_ovr_en, held);
      cmp("R3 pin_ovr_val", pin_ovr_val, held && m_phase != 1);
      cmp("R5 rel_stb", rel_stb, e_rel);
      cmp("R6 first_valid", first_valid, e_fv);
      cmp("R7 hold_err", hold_err, e_err);
      if (pin_ovr_en && !pin_ovr_val) n_pulse++;
      if (rel_stb) n_rel++;
      if (first_valid) n_fv++;
      if (mod_rst) n_rst++;
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_high(int ticks);
    @(negedge clk);
    sclk_in = 1'b1;
    wait_n(ticks * PER);
    sclk_in = 1'b0;
  endtask

  task automatic clear_counts();
    n_pulse = 0; n_rel = 0; n_fv = 0; n_rst = 0;
  endtask

  initial begin
    wait_n(3);
    cmp("R1 mod_rst in reset", mod_rst, 0);
    cmp("R1 pin_ovr_en in reset", pin_ovr_en, 0);
    cmp("R1 hold_err in reset", hold_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1 rel_stb after reset", rel_stb, 0);
    cmp("R1 first_valid after reset", first_valid, 0);
    cmp("R1 pin_ovr_val after reset", pin_ovr_val, 0);

    // R10 / R2: ticks with the clock low
    clear_counts();
    wait_n(5 * PER);
    cnt_chk("R10 no reset with clock low", n_rst, 0);

    // R9 / R2: three ticks, then a fall cancels
    clear_counts();
    hold_high(3);
    wait_n(2 * PER);
    cnt_chk("R9 short hold no pulse", n_pulse, 0);
    cnt_chk("R2 short hold no reset", n_rst, 0);

    // R3 R5 R6: five ticks then release
    clear_counts();
    hold_high(5);
    wait_n(DELAY + 4);
    cnt_chk("R3 one low pulse", n_pulse, 1);
    cnt_chk("R5 one release", n_rel, 1);
    cnt_chk("R6 one valid marker", n_fv, 1);

    // R3: exactly four ticks
    clear_counts();
    hold_high(4);
    wait_n(DELAY + 4);
    cnt_chk("R3 four ticks detect", n_pulse, 1);
    cnt_chk("R5 four ticks release", n_rel, 1);

    // R7 R8: over-long hold
    clear_counts();
    hold_high(21);
    wait_n(DELAY + 4);
    cnt_chk("R7 no release on over-long hold", n_rel, 0);
    cnt_chk("R7 no valid marker on over-long hold", n_fv, 0);
    cmp("R7 flag set", hold_err, 1);
    wait_n(3 * PER);
    cmp("R8 flag persists", hold_err, 1);

    // R8 R10: new request clears flag; activity during wait ignored
    clear_counts();
    hold_high(4);
    wait_n(2);
    sclk_in = 1'b1;
    wait_n(2);
    sclk_in = 1'b0;
    wait_n(DELAY + 4);
    cmp("R8 flag cleared", hold_err, 0);
    cnt_chk("R10 single release despite edges in wait", n_rel, 1);
    cnt_chk("R6 single valid marker", n_fv, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule